// File: doc/BRIEF.md
# Zero-overhead loop buffer controller

This block sits in a DSP fetch stage, between instruction memory and the decoder. It watches the instruction stream for two loop commands. A loop-start command carries a body length and an iteration count. The body that follows it is forwarded to the decoder and copied into a small local buffer at the same time. Every later pass is issued from that buffer, and memory fetching stops until the loop is done. A loop-repeat command runs the stored body again without fetching it.

The iteration count is a 7-bit immediate. When the immediate is zero, the count comes from a loop-counter register instead. Software can write that register while no loop is active. The register is reloaded when a loop starts and counts down once per completed pass. A control-transfer opcode found in a body while it is being captured raises a one-cycle error pulse. Malformed or premature commands also raise the pulse.

Both instruction streams use valid/ready handshakes. A word moves on a clock edge where valid and ready are both high. The memory side must hold its word stable while it is stalled. The output side holds `out_valid` and `out_data` steady until `out_ready` is seen. Back-pressure from the decoder stalls capture and replay alike.

Top module: `loop_buffer_ctrl`

## Requirements
- R1: Outside a loop, every word with an opcode (bits 31:28) other than 4'hE or 4'hD is forwarded unchanged and in order, with `in_ready` equal to `out_ready`. After reset, `busy`, `err`, `out_valid`, `fetch_addr` and `loop_cnt` are all zero.
- R2: A word with opcode 4'hE (loop start) is consumed and never forwarded. Its length field is bits 12:8, in the range 1 to 31, and its count immediate is bits 6:0. The next `n` words are forwarded and captured in the buffer.
- R3: After the captured pass, the remaining count−1 passes are issued from the buffer. During them `in_ready` is low and `fetch_addr` does not change.
- R4: A count immediate of zero takes the count from the loop-counter register. If that register holds zero, the body runs exactly once.
- R5: `loop_cnt` is loaded with the effective count when a loop starts, drops by one after each completed pass, and reads zero when the loop ends. A write while idle is visible on `loop_cnt` on the next cycle.
- R6: A word with opcode 4'hD (loop repeat) is consumed and replays the stored body for its count, using the same count rules as R4. Its length field is ignored, and only the command word itself is fetched.
- R7: A loop-repeat command when no body has been captured since reset is consumed, produces no output, leaves `busy` low and pulses `err` for one cycle.
- R8: A captured word with opcode 4'hC (control transfer) is still forwarded. `err` pulses high in the cycle after its handshake. Replays of that word raise no further pulse.
- R9: A loop-start command with length zero is consumed, pulses `err`, and starts no loop. The following words pass straight through.
- R10: When a started loop ends, `busy` falls and `fetch_addr` equals the command's address + 1 + n.
- R11: While `out_ready` is low, no word is dropped or repeated, in capture or in replay.
- R12: Writes to the loop-counter register while `busy` is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_addr | output | 16 | Address of the next word wanted from memory |
| in_valid | input | 1 | Memory word valid |
| in_data | input | 32 | Memory word |
| in_ready | output | 1 | Block accepts the memory word |
| out_valid | output | 1 | Instruction word valid toward decoder |
| out_data | output | 32 | Instruction word toward decoder |
| out_ready | input | 1 | Decoder accepts the word |
| cnt_wr_en | input | 1 | Software write strobe for the loop counter |
| cnt_wr_data | input | 16 | Value written to the loop counter |
| loop_cnt | output | 16 | Current loop-counter value |
| busy | output | 1 | A loop is capturing or replaying |
| err | output | 1 | One-cycle error pulse |

## Verification
The output-hold assertion takes for granted that memory keeps `in_valid` and `in_data` steady while its word is stalled. The bench's memory model meets this because it derives the word from `fetch_addr` and only ever extends the range of valid addresses. The checks also assume that software never writes the counter in the same cycle that a loop command is accepted. The bench writes the counter only between program segments, or once a loop is visibly busy.

// File: rtl/lbuf_pkg.sv
package lbuf_pkg;
  localparam int OPC_W = 4;
  localparam int LEN_W = 5;
  localparam int IMM_W = 7;
  localparam logic [OPC_W-1:0] OPC_START  = 4'hE;
  localparam logic [OPC_W-1:0] OPC_REPEAT = 4'hD;
  localparam logic [OPC_W-1:0] OPC_XFER   = 4'hC;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_PLAY = 2'd2
  } lbuf_state_t;

  typedef struct packed {
    logic             is_start;
    logic             is_repeat;
    logic             is_xfer;
    logic [LEN_W-1:0] len;
    logic [IMM_W-1:0] imm;
  } lbuf_cmd_t;
endpackage

// File: rtl/lbuf_decode.sv
module lbuf_decode
  import lbuf_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] word,
  output lbuf_cmd_t     cmd
);
  logic [OPC_W-1:0] opc;

  always_comb begin
    opc           = word[DW-1 -: OPC_W];
    cmd.is_start  = (opc == OPC_START);
    cmd.is_repeat = (opc == OPC_REPEAT);
    cmd.is_xfer   = (opc == OPC_XFER);
    cmd.len       = word[8 +: LEN_W];
    cmd.imm       = word[0 +: IMM_W];
  end
endmodule

// File: rtl/lbuf_store.sv
module lbuf_store #(
  parameter int DW    = 32,
  parameter int DEPTH = 31,
  parameter int PW    = 5
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [PW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] slot [DEPTH];

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (wr_en && (wr_idx == PW'(g))) slot[g] <= wr_data;
      end
    end
  endgenerate

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_idx == PW'(i)) rd_data = slot[i];
    end
  end
endmodule

// File: rtl/lbuf_seq.sv
module lbuf_seq
  import lbuf_pkg::*;
#(
  parameter int DEPTH = 31,
  parameter int CW    = 16,
  parameter int PW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  lbuf_cmd_t     cmd,
  input  logic          cmd_fire,
  input  logic          fill_fire,
  input  logic          play_fire,
  input  logic          cnt_wr_en,
  input  logic [CW-1:0] cnt_wr_data,
  output lbuf_state_t   state,
  output logic [PW-1:0] ptr,
  output logic [CW-1:0] cnt_q,
  output logic          err_q
);
  localparam logic [PW-1:0] MAX_LEN = PW'(DEPTH);

  logic [PW-1:0] len_q;
  logic          have_body;
  logic [CW-1:0] start_cnt;
  logic          pass_end;
  logic          last_pass;
  logic          len_bad;

  always_comb begin
    if (cmd.imm != '0)      start_cnt = CW'(cmd.imm);
    else if (cnt_q == '0)   start_cnt = CW'(1);
    else                    start_cnt = cnt_q;
    pass_end  = (fill_fire || play_fire) && (ptr == len_q - PW'(1));
    last_pass = (cnt_q <= CW'(1));
    len_bad   = (PW'(cmd.len) == '0) || (PW'(cmd.len) > MAX_LEN);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      ptr       <= '0;
      len_q     <= '0;
      cnt_q     <= '0;
      have_body <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      err_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (cnt_wr_en) cnt_q <= cnt_wr_data;
          if (cmd_fire && cmd.is_start) begin
            if (len_bad) err_q <= 1'b1;
            else begin
              len_q     <= PW'(cmd.len);
              ptr       <= '0;
              cnt_q     <= start_cnt;
              have_body <= 1'b0;
              state     <= ST_FILL;
            end
          end else if (cmd_fire && cmd.is_repeat) begin
            if (!have_body) err_q <= 1'b1;
            else begin
              ptr   <= '0;
              cnt_q <= start_cnt;
              state <= ST_PLAY;
            end
          end
        end
        ST_FILL: begin
          if (fill_fire) begin
            if (cmd.is_xfer) err_q <= 1'b1;
            if (pass_end) begin
              ptr       <= '0;
              cnt_q     <= cnt_q - CW'(1);
              have_body <= 1'b1;
              state     <= last_pass ? ST_IDLE : ST_PLAY;
            end else begin
              ptr <= ptr + PW'(1);
            end
          end
        end
        ST_PLAY: begin
          if (play_fire) begin
            if (pass_end) begin
              ptr   <= '0;
              cnt_q <= cnt_q - CW'(1);
              if (last_pass) state <= ST_IDLE;
            end else begin
              ptr <= ptr + PW'(1);
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |-> (ptr < len_q));

  // R5
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_end && !last_pass) |=> (cnt_q == $past(cnt_q) - CW'(1)));

  // R10
  loop_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_IDLE) && ($past(state) != ST_IDLE)) |-> $past(pass_end && last_pass));

  // R12
  busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_PLAY) && !play_fire) |=> $stable(cnt_q));
endmodule

// File: rtl/loop_buffer_ctrl.sv
module loop_buffer_ctrl
  import lbuf_pkg::*;
#(
  parameter int DW    = 32,
  parameter int AW    = 16,
  parameter int CW    = 16,
  parameter int DEPTH = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] fetch_addr,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  input  logic          out_ready,
  input  logic          cnt_wr_en,
  input  logic [CW-1:0] cnt_wr_data,
  output logic [CW-1:0] loop_cnt,
  output logic          busy,
  output logic          err
);
  localparam int PW = $clog2(DEPTH + 1);

  lbuf_cmd_t     cmd;
  lbuf_state_t   state;
  logic [PW-1:0] ptr;
  logic [DW-1:0] rd_data;
  logic          is_cmd_word;
  logic          cmd_fire;
  logic          fill_fire;
  logic          play_fire;

  lbuf_decode #(.DW(DW)) i_decode (
    .word (in_data),
    .cmd  (cmd)
  );

  always_comb begin
    is_cmd_word = cmd.is_start || cmd.is_repeat;
    out_valid   = 1'b0;
    out_data    = in_data;
    in_ready    = 1'b0;
    case (state)
      ST_IDLE: begin
        if (in_valid && is_cmd_word) begin
          in_ready = 1'b1;
        end else begin
          out_valid = in_valid;
          in_ready  = out_ready;
        end
      end
      ST_FILL: begin
        out_valid = in_valid;
        in_ready  = out_ready;
      end
      ST_PLAY: begin
        out_valid = 1'b1;
        out_data  = rd_data;
      end
      default: ;
    endcase
    cmd_fire  = (state == ST_IDLE) && in_valid && is_cmd_word;
    fill_fire = (state == ST_FILL) && in_valid && out_ready;
    play_fire = (state == ST_PLAY) && out_ready;
  end

  lbuf_store #(.DW(DW), .DEPTH(DEPTH), .PW(PW)) i_store (
    .clk     (clk),
    .wr_en   (fill_fire),
    .wr_idx  (ptr),
    .wr_data (in_data),
    .rd_idx  (ptr),
    .rd_data (rd_data)
  );

  lbuf_seq #(.DEPTH(DEPTH), .CW(CW), .PW(PW)) i_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd         (cmd),
    .cmd_fire    (cmd_fire),
    .fill_fire   (fill_fire),
    .play_fire   (play_fire),
    .cnt_wr_en   (cnt_wr_en),
    .cnt_wr_data (cnt_wr_data),
    .state       (state),
    .ptr         (ptr),
    .cnt_q       (loop_cnt),
    .err_q       (err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) fetch_addr <= '0;
    else if (in_valid && in_ready) fetch_addr <= fetch_addr + AW'(1);
  end

  assign busy = (state != ST_IDLE);

  // R3
  replay_nofetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PLAY) |=> $stable(fetch_addr));

  // R11
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R2
  cmd_not_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire |-> !out_valid);
endmodule

// File: tb/test_loop_buffer_ctrl.sv
module test_loop_buffer_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] fetch_addr;
  logic        in_valid;
  logic [31:0] in_data;
  logic        in_ready;
  logic        out_valid;
  logic [31:0] out_data;
  logic        out_ready = 1'b1;
  logic        cnt_wr_en;
  logic [15:0] cnt_wr_data;
  logic [15:0] loop_cnt;
  logic        busy;
  logic        err;

  logic [31:0] prog [0:1023];
  int          avail = 0;
  int          wp = 0;
  logic [31:0] expq [$];
  int          total = 0;
  int          bad = 0;
  int          err_seen = 0;
  bit          stall_mode = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  string       cur_req = "R1";
  bit          done = 1'b0;

  always #4 clk = ~clk;

  assign in_valid = (int'(fetch_addr) < avail);
  assign in_data  = prog[fetch_addr[9:0]];

  loop_buffer_ctrl i_loop_buffer_ctrl (
    .clk(clk), .rst_n(rst_n), .fetch_addr(fetch_addr),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data),
    .loop_cnt(loop_cnt), .busy(busy), .err(err)
  );

  // monitor: drive ready, then compare handshakes against the queue
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = stall_mode ? (lfsr[0] | lfsr[5]) : 1'b1;
    #1;
    if (rst_n === 1'b1) begin
      if (err === 1'b1) err_seen++;
      if (out_valid && out_ready) begin
        total++;
        if (expq.size() == 0) begin
          bad++;
          $display("FAIL %s (R11): unexpected word actual=%h expected=none", cur_req, out_data);
        end else begin
          logic [31:0] e;
          e = expq.pop_front();
          if (out_data !== e) begin
            bad++;
            $display("FAIL %s (R11): word actual=%h expected=%h", cur_req, out_data, e);
          end
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  task automatic put(input logic [31:0] w);
    prog[wp] = w;
    wp++;
  endtask

  function automatic logic [31:0] w_start(input int n, input int k);
    return 32'hE000_0000 | (32'(n) << 8) | 32'(k);
  endfunction

  function automatic logic [31:0] w_repeat(input int n, input int k);
    return 32'hD000_0000 | (32'(n) << 8) | 32'(k);
  endfunction

  task automatic settle();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk); #2;
      if (expq.size() == 0 && busy == 1'b0 && int'(fetch_addr) == avail) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic run_seg();
    avail = wp;
    settle();
  endtask

  // driver: appends a loop and pushes its expected output
  task automatic add_loop(input int n, input int k, input int eff, input int xfer_at, input logic [31:0] base);
    logic [31:0] body [32];
    put(w_start(n, k));
    for (int i = 0; i < n; i++) begin
      body[i] = (i == xfer_at) ? (32'hC000_0000 | base | 32'(i)) : (32'h1000_0000 | base | 32'(i));
      put(body[i]);
    end
    for (int p = 0; p < eff; p++)
      for (int i = 0; i < n; i++) expq.push_back(body[i]);
  endtask

  task automatic cnt_write(input logic [15:0] v);
    @(negedge clk);
    cnt_wr_en = 1'b1; cnt_wr_data = v;
    @(negedge clk);
    cnt_wr_en = 1'b0;
  endtask

  initial begin
    int a;
    int e0;
    rst_n = 1'b0; cnt_wr_en = 1'b0; cnt_wr_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); #2;
    // R1 reset state
    chk(busy == 1'b0, "R1 busy", 32'(busy), 0);
    chk(err == 1'b0, "R1 err", 32'(err), 0);
    chk(out_valid == 1'b0, "R1 out_valid", 32'(out_valid), 0);
    chk(fetch_addr == 16'd0, "R1 fetch_addr", 32'(fetch_addr), 0);
    chk(loop_cnt == 16'd0, "R1 loop_cnt", 32'(loop_cnt), 0);
    rst_n = 1'b1;

    // R7 repeat before any capture
    cur_req = "R7";
    put(w_repeat(2, 3));
    run_seg();
    chk(err_seen == 1, "R7 err pulses", 32'(err_seen), 1);
    chk(busy == 1'b0, "R7 busy", 32'(busy), 0);
    chk(fetch_addr == 16'd1, "R7 fetch_addr", 32'(fetch_addr), 1);

    // R1 pass-through
    cur_req = "R1";
    for (int i = 0; i < 4; i++) begin
      put(32'h2000_0000 | 32'(i));
      expq.push_back(32'h2000_0000 | 32'(i));
    end
    run_seg();

    // R9 zero length
    cur_req = "R9";
    e0 = err_seen;
    put(w_start(0, 2));
    put(32'h2000_00AA);
    expq.push_back(32'h2000_00AA);
    run_seg();
    chk(err_seen == e0 + 1, "R9 err pulses", 32'(err_seen - e0), 1);

    // R2 R3 R5 R10 basic loop
    cur_req = "R2";
    a = wp;
    add_loop(3, 4, 4, -1, 32'h0000_0100);
    run_seg();
    chk(int'(fetch_addr) == a + 4, "R10 fetch_addr after loop", 32'(fetch_addr), 32'(a + 4));
    chk(loop_cnt == 16'd0, "R5 loop_cnt end", 32'(loop_cnt), 0);
    chk(busy == 1'b0, "R10 busy end", 32'(busy), 0);

    // R4 count from register
    cur_req = "R4";
    cnt_write(16'd5);
    @(negedge clk); #2;
    chk(loop_cnt == 16'd5, "R5 write visible", 32'(loop_cnt), 5);
    add_loop(2, 0, 5, -1, 32'h0000_0200);
    run_seg();
    chk(loop_cnt == 16'd0, "R4 loop_cnt end", 32'(loop_cnt), 0);

    // R4 register zero -> once
    cnt_write(16'd0);
    add_loop(2, 0, 1, -1, 32'h0000_0300);
    run_seg();

    // R6 repeat stored body (len field ignored)
    cur_req = "R6";
    a = wp;
    put(w_repeat(7, 3));
    for (int p = 0; p < 3; p++)
      for (int i = 0; i < 2; i++) expq.push_back(32'h1000_0300 | 32'(i));
    run_seg();
    chk(int'(fetch_addr) == a + 1, "R6 no body fetch", 32'(fetch_addr), 32'(a + 1));

    // R8 control transfer inside body
    cur_req = "R8";
    e0 = err_seen;
    add_loop(3, 2, 2, 1, 32'h0000_0400);
    run_seg();
    chk(err_seen == e0 + 1, "R8 err pulses", 32'(err_seen - e0), 1);

    // R11 back-pressure, n=31 and n=1 boundaries
    cur_req = "R11";
    stall_mode = 1'b1;
    a = wp;
    add_loop(31, 2, 2, -1, 32'h0000_0500);
    add_loop(1, 5, 5, -1, 32'h0000_0600);
    put(w_repeat(1, 2));
    expq.push_back(32'h1000_0600);
    expq.push_back(32'h1000_0600);
    run_seg();
    chk(int'(fetch_addr) == a + 35, "R10 fetch_addr after stalls", 32'(fetch_addr), 32'(a + 35));
    stall_mode = 1'b0;

    // R12 write while busy ignored
    cur_req = "R12";
    add_loop(4, 3, 3, -1, 32'h0000_0700);
    avail = wp;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk); #2;
      if (busy) break;
    end
    cnt_write(16'd50);
    settle();
    chk(loop_cnt == 16'd0, "R12 loop_cnt after busy write", 32'(loop_cnt), 0);
    chk(expq.size() == 0, "R12 all words seen", 32'(expq.size()), 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule